// File: doc/BRIEF.md
# Twelve-Bit Floating-Point Adder/Subtractor

This block adds or subtracts two numbers held in a compact 12-bit floating-point layout. Bit 11 is the sign, bits 10:5 hold a 6-bit biased exponent and bits 4:0 hold a 5-bit fraction. A normal value carries an implied leading one. An exponent of zero encodes the value zero, whatever its fraction bits hold. Infinities, NaNs, subnormals and round-to-nearest are not supported. Every result is truncated.

On each clock the block takes two operands and a subtract control, and it registers one result. The operand with the smaller magnitude is shifted right by the exponent difference into a significand that is three bits wider than the stored one. Bits shifted out beyond that extension are discarded. The two significands are then added or subtracted according to the effective signs. The sum is renormalised, either by one right step on a carry or by a left shift of as many places as there are leading zeros, and the fraction is then truncated to five bits.

The block is meant for datapaths such as filter sections that need a cheap arithmetic unit with a fixed latency of one cycle.

Top module: `fp12_adder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sum_o` becomes 12'h000.
- R2: `sum_o` shows the result for the operands present at a rising edge, from that edge onward. Before that edge it keeps the previous result.
- R3: When the effective signs are equal and the significand sum carries out, the result exponent is the larger exponent plus one. The result keeps the common sign, and its fraction is the five bits below the carry.
- R4: The smaller-magnitude operand is aligned by a right shift equal to the exponent difference, and result fraction bits are truncated. When the difference is 9 or more, the result equals the larger operand.
- R5: With `sub`=1 the sign of `op_b` is inverted before the operation. On effective subtraction the result takes the sign of the larger-magnitude operand. When the magnitudes are equal, `op_a` counts as the larger.
- R6: After a cancellation the result is shifted left by its number of leading zeros, and its exponent is lowered by that same count.
- R7: A zero result, including exact cancellation and zero plus zero, is encoded as 12'h000, so its sign is positive.
- R8: An operand whose exponent field (bits 10:5) is 0 is treated as zero, whatever its fraction bits hold.
- R9: If the result exponent would exceed 63, the result saturates to exponent 63 with fraction 5'b11111, and the sign is kept.
- R10: If the result exponent would fall below 1, the result is 12'h000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 12 | First operand {sign, exponent, fraction} |
| op_b | input | 12 | Second operand {sign, exponent, fraction} |
| sub | input | 1 | 1 selects op_a minus op_b |
| sum_o | output | 12 | Registered result |

## Verification
The assertions assume that the operands, `sub` and `rst_n` are stable and known at each rising edge, because they compare the registered result with `$past` of the decoded inputs. They also assume that reset has been applied once. The bench meets both assumptions. It holds reset for several edges with zero operands, and it changes inputs only on falling edges. It uses only well-formed 12-bit patterns. Some of these patterns deliberately place non-zero fraction bits under a zero exponent.

// File: rtl/fp12_adder.sv
module fp12_adder #(
  parameter int EW = 6,
  parameter int FW = 5,
  parameter int GW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EW+FW:0]    op_a,
  input  logic [EW+FW:0]    op_b,
  input  logic              sub,
  output logic [EW+FW:0]    sum_o
);
  localparam int W  = 1 + EW + FW;
  localparam int MW = FW + 1;
  localparam int AW = MW + GW;
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};

  logic          sa, sb, a_zero, b_zero, swap, eff_sub, sL;
  logic [EW-1:0] ea, eb, eL, eS, d, lz;
  logic [FW-1:0] fa, fb;
  logic [MW-1:0] mL, mS;
  logic [AW-1:0] lx, sx, norm;
  logic [AW:0]   raw;
  logic [W-1:0]  res;
  logic          found;

  assign sa = op_a[W-1];
  assign sb = op_b[W-1] ^ sub;
  assign ea = op_a[W-2:FW];
  assign eb = op_b[W-2:FW];
  assign fa = op_a[FW-1:0];
  assign fb = op_b[FW-1:0];
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign eff_sub = sa ^ sb;

  assign swap = a_zero ? !b_zero : (!b_zero && ({eb, fb} > {ea, fa}));
  assign eL = swap ? eb : ea;
  assign eS = swap ? ea : eb;
  assign sL = swap ? sb : sa;
  assign mL = swap ? (b_zero ? '0 : {1'b1, fb}) : (a_zero ? '0 : {1'b1, fa});
  assign mS = swap ? (a_zero ? '0 : {1'b1, fa}) : (b_zero ? '0 : {1'b1, fb});
  assign d  = eL - eS;
  assign lx = {mL, {GW{1'b0}}};
  assign sx = (d >= EW'(AW)) ? '0 : ({mS, {GW{1'b0}}} >> d);
  assign raw = eff_sub ? ({1'b0, lx} - {1'b0, sx}) : ({1'b0, lx} + {1'b0, sx});

  always_comb begin
    lz = '0;
    found = 1'b0;
    for (int i = AW - 1; i >= 0; i--) begin
      if (!found && raw[i]) begin
        lz = EW'(AW - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign norm = raw[AW-1:0] << lz;

  always_comb begin
    if (raw == '0)
      res = '0;
    else if (raw[AW]) begin
      if (eL == EMAX)
        res = {sL, EMAX, {FW{1'b1}}};
      else
        res = {sL, eL + 1'b1, raw[AW-1 -: FW]};
    end else if (lz >= eL)
      res = '0;
    else
      res = {sL, eL - lz, norm[AW-2 -: FW]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sum_o <= '0;
    else        sum_o <= res;
  end

  a_r7_zero_is_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_o[W-2:FW] == '0) |-> (sum_o == '0));

  a_r3_add_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!eff_sub && !(a_zero && b_zero)) && $past(rst_n))
      |-> (sum_o[W-2:FW] >= $past(eL)) && (sum_o[W-1] == $past(sL)));

  a_r5_sub_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eff_sub) && $past(rst_n) && (sum_o != '0))
      |-> (sum_o[W-2:FW] <= $past(eL)) && (sum_o[W-1] == $past(sL)));

  a_r8_zero_operand_passes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(b_zero) && !$past(a_zero)) |-> (sum_o == $past(op_a)));

  a_r7_both_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(a_zero && b_zero)) |-> (sum_o == '0));
endmodule

// File: tb/fp12_adder_test.sv
module fp12_adder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] op_a = '0, op_b = '0;
  logic sub = 1'b0;
  logic [11:0] sum_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp12_adder uut (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub(sub), .sum_o(sum_o));

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b_%b_%b expected %b_%b_%b", req,
               got[11], got[10:5], got[4:0], exp[11], exp[10:5], exp[4:0]);
    end
  endtask

  task automatic run(input string req, input logic [11:0] a, input logic [11:0] b,
                     input logic s, input logic [11:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; sub = s;
    @(posedge clk); #1;
    check(req, sum_o, exp);
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    check("R1 reset", sum_o, 12'h000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_latency;
    run("R2 first", 12'b0_100001_00100, 12'b0_100000_01000, 1'b0, 12'b0_100001_11000);
    @(negedge clk);
    op_a = 12'b0_100001_00010; op_b = 12'b0_100001_11110;
    #5 check("R2 held before edge", sum_o, 12'b0_100001_11000);
    @(posedge clk); #1;
    check("R2 after edge", sum_o, 12'b0_100010_10000);
  endtask

  task automatic t_carry;
    run("R3 neg carry", 12'b1_100100_11110, 12'b1_100010_11000, 1'b0, 12'b1_100101_00110);
    run("R3 pos carry", 12'b0_100100_11110, 12'b0_100010_11000, 1'b0, 12'b0_100101_00110);
  endtask

  task automatic t_align;
    run("R4 truncate", 12'b0_100001_01110, 12'b0_100000_00001, 1'b0, 12'b0_100001_11110);
    run("R4 far apart", 12'b0_101000_00101, 12'b0_011110_11111, 1'b0, 12'b0_101000_00101);
  endtask

  task automatic t_sub;
    run("R5 sub larger b", 12'b0_100000_00000, 12'b0_100001_00000, 1'b1, 12'b1_100000_00000);
    run("R5 mixed sign", 12'b1_100010_00000, 12'b0_100000_00000, 1'b0, 12'b1_100001_10000);
  endtask

  task automatic t_renorm;
    run("R6 cancel", 12'b0_011110_00000, 12'b1_011101_11000, 1'b0, 12'b0_011011_00000);
  endtask

  task automatic t_zero;
    run("R7 x minus x", 12'b0_100101_10101, 12'b0_100101_10101, 1'b1, 12'h000);
    run("R7 neg plus pos", 12'b1_011111_00011, 12'b0_011111_00011, 1'b0, 12'h000);
    run("R7 zero plus zero", 12'h000, 12'h000, 1'b0, 12'h000);
  endtask

  task automatic t_zero_operand;
    run("R8 zero exp a", 12'b0_000000_10101, 12'b1_100010_01100, 1'b0, 12'b1_100010_01100);
    run("R8 zero exp b sub", 12'b0_100011_00111, 12'b1_000000_11111, 1'b1, 12'b0_100011_00111);
  endtask

  task automatic t_overflow;
    run("R9 pos sat", 12'b0_111111_11111, 12'b0_111111_11111, 1'b0, 12'b0_111111_11111);
    run("R9 neg sat", 12'b1_111111_10000, 12'b1_111111_10000, 1'b0, 12'b1_111111_11111);
  endtask

  task automatic t_underflow;
    run("R10 flush", 12'b0_000001_10000, 12'b1_000001_00000, 1'b0, 12'h000);
    run("R10 edge keep", 12'b0_000010_10000, 12'b1_000010_00000, 1'b0, 12'b0_000001_00000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_latency();
    t_carry();
    t_align();
    t_sub();
    t_renorm();
    t_zero();
    t_zero_operand();
    t_overflow();
    t_underflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule